// File: doc/BRIEF.md
# Forwarded-Clock Sample Capture for a 10-Bit Converter

This block receives parallel samples from a high-speed 10-bit converter, clocked by the data clock the converter forwards. In single-edge mode, ten lanes carry a whole sample and are captured on the rising edge. In dual-edge mode, five lanes carry half a sample on each edge. The block captures both halves and rebuilds the full word. Both modes yield one sample per clock period.

The converter's range flag is registered in the same stage as the rising-edge capture, so it stays with its own sample. The flag is combined with the raw most significant bit to report an over-range or an under-range condition. Samples can pass through in offset binary or be converted to twos complement. The result leaves the block through registers, as a word, a valid strobe and two range flags.

Top module: `adc_lvds_capture`

## Requirements
- R1: With `ddr_mode` = 0, `lane_in[i]` is bit i of the sample. It is captured on a rising edge and the word is presented on `sample_out` after the next rising edge.
- R2: With `ddr_mode` = 1, only `lane_in[4:0]` are used. Lane i sampled on a rising edge is bit 2i+1, and lane i sampled on the following falling edge is bit 2i. The merged word appears on `sample_out` after the next rising edge.
- R3: In a steady stream, `valid_out` is high every cycle in either mode. Whenever `valid_out` is low, `sample_out`, `over_out` and `under_out` are 0.
- R4: The range flag `range_in` is captured with the rising-edge part of its sample. `over_out` = flag AND raw bit 9, and `under_out` = flag AND NOT raw bit 9, both judged on the offset-binary value before any format conversion. The two are never high together.
- R5: While `rst` is high at a rising edge, every output is cleared and the capture mode reverts to single-edge. The output after the first rising edge with `rst` low has `valid_out` = 0.
- R6: A sample captured on a rising edge where `ddr_mode` differs from its value at the previous rising edge is dropped: its output cycle has `valid_out` = 0.
- R7: `twos_fmt` is sampled together with the sample. At 0 the offset-binary word passes unchanged; at 1 bit 9 is inverted, so 1111111111 leaves as +511 (0111111111) and 0000000000 as -512 (1000000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded data clock from the converter |
| rst | input | 1 | Synchronous active-high reset |
| ddr_mode | input | 1 | 0 = ten lanes on rising edge, 1 = five lanes on both edges |
| twos_fmt | input | 1 | 1 = convert the sample to twos complement |
| lane_in | input | 10 | Received data lanes |
| range_in | input | 1 | Converter out-of-range flag, aligned with the rising-edge data |
| sample_out | output | 10 | Reassembled and formatted sample |
| valid_out | output | 1 | High for one cycle per delivered sample |
| over_out | output | 1 | Sample is above full scale |
| under_out | output | 1 | Sample is below full scale |

## Verification
A sample is captured on a rising edge, and in dual-edge mode completed on the following falling edge. It is due on the outputs one rising edge later. The bench feeds each stimulus through a seven-stage model of the converter's pipeline before driving it onto the lanes. It then compares every output two nanoseconds after the rising edge that should carry it, against the sample driven one step earlier. Lanes are driven two nanoseconds after an edge, so each capture edge meets stable data. Valid expectations follow a bench model of the mode register, so the drop after reset or after a mode switch is checked at the exact cycle it is due.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic {
    CAP_SINGLE = 1'b0,
    CAP_DUAL   = 1'b1
  } cap_mode_e;

  typedef struct packed {
    logic over;
    logic under;
  } range_flags_t;

endpackage

// File: rtl/adc_lane_capture.sv
module adc_lane_capture #(
  parameter int W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   lanes,
  output logic [W-1:0]   rise_q,
  output logic [W/2-1:0] fall_q
);
  localparam int HALF = W / 2;

  // rising edge: all lanes (full word, or odd half in dual-edge form)
  always_ff @(posedge clk) begin
    if (rst) rise_q <= '0;
    else     rise_q <= lanes;
  end

  // falling edge: lower lanes only (even half in dual-edge form)
  always_ff @(negedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= lanes[HALF-1:0];
  end
endmodule

// File: rtl/adc_word_assemble.sv
module adc_word_assemble
  import adc_cap_pkg::*;
#(
  parameter int W = 10
) (
  input  cap_mode_e      mode,
  input  logic [W-1:0]   rise_q,
  input  logic [W/2-1:0] fall_q,
  output logic [W-1:0]   word
);
  localparam int HALF = W / 2;

  logic [W-1:0] dual_word;

  for (genvar i = 0; i < HALF; i++) begin : g_interleave
    assign dual_word[2*i+1] = rise_q[i];
    assign dual_word[2*i]   = fall_q[i];
  end

  always_comb begin
    if (mode == CAP_DUAL) word = dual_word;
    else                  word = rise_q;
  end
endmodule

// File: rtl/adc_range_format.sv
module adc_range_format
  import adc_cap_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0] raw,
  input  logic         flag,
  input  logic         to_twos,
  output logic [W-1:0] fmt_word,
  output range_flags_t flags
);
  localparam logic [W-1:0] SIGN_MASK = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    fmt_word    = to_twos ? (raw ^ SIGN_MASK) : raw;
    flags.over  = flag &  raw[W-1];
    flags.under = flag & ~raw[W-1];
  end
endmodule

// File: rtl/adc_lvds_capture.sv
module adc_lvds_capture
  import adc_cap_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ddr_mode,
  input  logic         twos_fmt,
  input  logic [W-1:0] lane_in,
  input  logic         range_in,
  output logic [W-1:0] sample_out,
  output logic         valid_out,
  output logic         over_out,
  output logic         under_out
);
  localparam int HALF = W / 2;

  logic [W-1:0]    rise_q;
  logic [HALF-1:0] fall_q;
  logic            flag_q;
  logic            fmt_q;
  logic            cap_ok;
  cap_mode_e       mode_q;
  cap_mode_e       mode_in;
  logic [W-1:0]    raw_word;
  logic [W-1:0]    fmt_word;
  range_flags_t    flags;

  assign mode_in = cap_mode_e'(ddr_mode);

  adc_lane_capture #(.W(W)) u_capture (
    .clk    (clk),
    .rst    (rst),
    .lanes  (lane_in),
    .rise_q (rise_q),
    .fall_q (fall_q)
  );

  // side-band captured in the same rising-edge stage as the data
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      fmt_q  <= 1'b0;
      cap_ok <= 1'b0;
      mode_q <= CAP_SINGLE;
    end else begin
      flag_q <= range_in;
      fmt_q  <= twos_fmt;
      cap_ok <= (mode_in == mode_q);
      mode_q <= mode_in;
    end
  end

  adc_word_assemble #(.W(W)) u_assemble (
    .mode   (mode_q),
    .rise_q (rise_q),
    .fall_q (fall_q),
    .word   (raw_word)
  );

  adc_range_format #(.W(W)) u_format (
    .raw      (raw_word),
    .flag     (flag_q),
    .to_twos  (fmt_q),
    .fmt_word (fmt_word),
    .flags    (flags)
  );

  always_ff @(posedge clk) begin
    if (rst || !cap_ok) begin
      sample_out <= '0;
      valid_out  <= 1'b0;
      over_out   <= 1'b0;
      under_out  <= 1'b0;
    end else begin
      sample_out <= fmt_word;
      valid_out  <= 1'b1;
      over_out   <= flags.over;
      under_out  <= flags.under;
    end
  end
endmodule

// File: rtl/adc_lvds_capture_chk.sv
module adc_lvds_capture_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         ddr_mode,
  input logic         twos_fmt,
  input logic [W-1:0] lane_in,
  input logic         range_in,
  input logic [W-1:0] sample_out,
  input logic         valid_out,
  input logic         over_out,
  input logic         under_out
);
  // R4: never both range flags
  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(over_out && under_out));

  // R3: idle outputs are quiet
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !valid_out |-> (sample_out == '0 && !over_out && !under_out));

  // R5: first output after reset release is not valid
  p_reset_gap_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> !valid_out);

  // R6: a mode switch drops the sample captured with it
  p_mode_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (ddr_mode != $past(ddr_mode)) |=> ##1 !valid_out);

  // R1 and R7: single-edge data two samples back, with sign bit per format
  p_single_data_r1: assert property (@(posedge clk) disable iff (rst)
    (valid_out && !$past(ddr_mode, 2)) |->
      ({sample_out[W-1] ^ $past(twos_fmt, 2), sample_out[W-2:0]} == $past(lane_in, 2)));

  // R4: a flagged sample raises one range output
  p_flag_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_out && $past(range_in, 2)) |-> (over_out || under_out));
endmodule

bind adc_lvds_capture adc_lvds_capture_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ddr_mode   (ddr_mode),
  .twos_fmt   (twos_fmt),
  .lane_in    (lane_in),
  .range_in   (range_in),
  .sample_out (sample_out),
  .valid_out  (valid_out),
  .over_out   (over_out),
  .under_out  (under_out)
);

// File: tb/adc_lvds_capture_tb_top.sv
module adc_lvds_capture_tb_top;
  localparam int W   = 10;
  localparam int H   = W / 2;
  localparam int LAT = 7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ddr_mode = 1'b0;
  logic         twos_fmt = 1'b0;
  logic [W-1:0] lane_in = '0;
  logic         range_in = 1'b0;
  logic [W-1:0] sample_out;
  logic         valid_out;
  logic         over_out;
  logic         under_out;

  always #5 clk = ~clk;

  adc_lvds_capture #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .ddr_mode(ddr_mode), .twos_fmt(twos_fmt),
    .lane_in(lane_in), .range_in(range_in), .sample_out(sample_out),
    .valid_out(valid_out), .over_out(over_out), .under_out(under_out)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // converter pipeline model: {flag, code}
  logic [W:0] pipe [LAT];
  logic       mode_model = 1'b0;
  logic       prev_v = 1'b0;
  logic [W-1:0] prev_code = '0;
  logic       prev_flag = 1'b0;
  logic       prev_fmt = 1'b0;
  logic       prev_ddr = 1'b0;

  task automatic cmp(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_out(input logic v, input logic [W-1:0] code,
                           input logic flg, input logic fmt, input logic was_ddr);
    logic [W-1:0] e_word;
    e_word = v ? (fmt ? {~code[W-1], code[W-2:0]} : code) : '0;
    cmp("R3 R5 R6 valid", int'(valid_out), int'(v));
    if (was_ddr) cmp("R2 R7 dual-edge word", int'(sample_out), int'(e_word));
    else         cmp("R1 R7 single-edge word", int'(sample_out), int'(e_word));
    cmp("R4 over", int'(over_out), int'(v & flg & code[W-1]));
    cmp("R4 under", int'(under_out), int'(v & flg & ~code[W-1]));
  endtask

  task automatic step(input logic [W-1:0] code, input logic flg,
                      input logic use_ddr, input logic fmt, input logic r);
    logic [W:0]   out_s;
    logic [W-1:0] word;
    logic         cur_v;
    out_s = pipe[LAT-1];
    for (int i = LAT-1; i > 0; i--) pipe[i] = pipe[i-1];
    pipe[0] = {flg, code};
    word = out_s[W-1:0];
    @(negedge clk); #2;
    rst = r; ddr_mode = use_ddr; twos_fmt = fmt; range_in = out_s[W];
    if (!use_ddr) lane_in = word;
    else begin
      lane_in = '0;
      for (int i = 0; i < H; i++) lane_in[i] = word[2*i+1];
    end
    cur_v = !r && (use_ddr == mode_model);
    mode_model = r ? 1'b0 : use_ddr;
    @(posedge clk); #2;
    check_out(prev_v && !r, prev_code, prev_flag, prev_fmt, prev_ddr);
    if (use_ddr) begin
      lane_in = '0;
      for (int i = 0; i < H; i++) lane_in[i] = word[2*i];
    end
    prev_v = cur_v; prev_code = word; prev_flag = out_s[W];
    prev_fmt = fmt; prev_ddr = use_ddr;
  endtask

  initial begin
    for (int i = 0; i < LAT; i++) pipe[i] = '0;
    // R5: reset state
    for (int i = 0; i < 3; i++) step('0, 1'b0, 1'b0, 1'b0, 1'b1);
    cmp("R5 reset sample", int'(sample_out), 0);
    cmp("R5 reset valid", int'(valid_out), 0);
    // R1 R4: single-edge sweep, both flag values
    for (int i = 0; i < 2048; i++) step(W'(i), i[10], 1'b0, 1'b0, 1'b0);
    // R7: single-edge with conversion
    for (int i = 0; i < 1024; i++) step(W'(i), i[0], 1'b0, 1'b1, 1'b0);
    // R2 R6: switch to dual-edge, full sweep
    for (int i = 0; i < 2048; i++) step(W'(i), i[10], 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 1024; i++) step(W'(1023 - i), i[1], 1'b1, 1'b1, 1'b0);
    // R6: frequent mode switches
    for (int i = 0; i < 120; i++) step(W'(i * 37), i[2], ((i / 5) % 2) == 1, i[3], 1'b0);
    // R5: reset while dual-edge selected, mode returns to single-edge
    for (int i = 0; i < 2; i++) step(W'(i), 1'b1, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) step(W'(i * 51), 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) step(W'(i * 29), i[0], 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < LAT + 2; i++) step('0, 1'b0, 1'b0, 1'b0, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule